// File: doc/BRIEF.md
# Cache Error Status Monitor

This block observes the control events of a small write-back cache with four lines and records anomalies in a sticky status register. It watches three kinds of input: the per-line tag-match vectors for reads and writes, the per-line valid and dirty flags with their line tags, and events from outside the cache. The outside events are snoop accesses from other agents, invalidate requests from a buffer manager and a negative acknowledge from the address-mapping unit. Each anomaly raises one status bit, and the bit stays set until software clears it.

Software reaches the register through two write ports, selected by `sw_sel`. One sets the written 1s and the other clears them. The current value is always visible on `status`. A negative acknowledge also triggers a one-cycle request to patch a packet header word. The word carries the failing offset and a fixed error signature.

Top module: `cache_err_monitor`

## Requirements
- R1: After reset, `status` is 0x00 and `patch_valid` is 0.
- R2: A software write with `sw_sel`=0 ORs `sw_wdata` into `status`. A software write with `sw_sel`=1 clears every bit where `sw_wdata` is 1 and leaves the other bits unchanged. Either write takes effect on the next clock edge.
- R3: Bit 7 is set one cycle after `inval_req` names, through `inval_line`, a line that is both valid and dirty. A request for a clean or invalid line leaves bit 7 at 0.
- R4: Bit 6 is set one cycle after `wr_en` arrives with two or more bits of `wr_hit & line_valid` set. Zero or one matching valid line leaves bit 6 at 0.
- R5: Bit 5 is set one cycle after `rd_en` arrives with two or more bits of `rd_hit & line_valid` set. Zero or one matching valid line leaves bit 5 at 0.
- R6: Bit 4 is set one cycle after `nack_pulse` is high.
- R7: In the cycle after `nack_pulse`, `patch_valid` is 1 for exactly one cycle. `patch_hdr_ofs` is 0x0C. `patch_data` is {`nack_offset`[19:0], 12'hBAD}, with the signature in bits 11:0.
- R8: Bit n (n = 0..3) is set one cycle after `snoop_valid` arrives with `snoop_line` equal to the tag of line n (`line_tag`[26n+25:26n]) while line n is valid and dirty. Clean lines, invalid lines and addresses that do not match never set a collision bit.
- R9: Status bits are sticky. A set bit stays set until a clear write hits it. If a hardware event and a software clear hit the same bit in the same cycle, the bit ends up set.
- R10: Tag-match vectors have no effect while their strobe (`rd_en` or `wr_en`) is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Read access strobe |
| rd_hit | input | 4 | Per-line read tag-match vector |
| wr_en | input | 1 | Write access strobe |
| wr_hit | input | 4 | Per-line write tag-match vector |
| line_valid | input | 4 | Per-line valid flags |
| line_dirty | input | 4 | Per-line dirty flags |
| line_tag | input | 104 | Line-aligned tags, 26 bits per line, line 0 lowest |
| snoop_valid | input | 1 | Another agent accesses memory |
| snoop_line | input | 26 | Line-aligned address of that access |
| inval_req | input | 1 | Invalidate request from the buffer manager |
| inval_line | input | 2 | Line index of the invalidate request |
| nack_pulse | input | 1 | Negative acknowledge from the address-mapping unit |
| nack_offset | input | 20 | Offset of the failing write in the packet |
| sw_wr | input | 1 | Software write strobe |
| sw_sel | input | 1 | 0 selects the set port, 1 selects the clear port |
| sw_wdata | input | 8 | Software write data |
| status | output | 8 | Current status register value |
| patch_valid | output | 1 | Header patch request |
| patch_hdr_ofs | output | 8 | Header offset of the patch word |
| patch_data | output | 32 | Patch word: offset and signature |

## Verification
The bench builds the block with its default four lines and 26-bit tags. With these values every combination of valid and dirty flags against every hit vector, snoop target and invalidate index fits in a few thousand cycles. The read and write multi-hit detectors are therefore swept exhaustively over all 256 pairs of hit vector and valid flags. Collision and invalidate detection are swept over every valid/dirty pattern for every line. The bench also checks the patch word at several offsets and the interaction of set-wins with a same-cycle clear.

// File: rtl/cem_pkg.sv
package cem_pkg;
    // status bit positions above the per-line collision field
    localparam int EVT_NACK      = 0;
    localparam int EVT_RD_MULTI  = 1;
    localparam int EVT_WR_MULTI  = 2;
    localparam int EVT_INV_DIRTY = 3;
    localparam int NUM_EVT       = 4;

    typedef enum logic {
        SW_SEL_SET = 1'b0,
        SW_SEL_CLR = 1'b1
    } sw_sel_e;
endpackage

// File: rtl/cem_multihit.sv
module cem_multihit #(
    parameter int N = 4
) (
    input  logic         en,
    input  logic [N-1:0] hit,
    input  logic [N-1:0] valid,
    output logic         multi
);
    localparam logic [N-1:0] ONE = N'(1);

    logic [N-1:0] match_d;

    always_comb begin
        match_d = hit & valid;
        // more than one bit set iff clearing the lowest set bit leaves something
        multi   = en && ((match_d & (match_d - ONE)) != '0);
    end
endmodule

// File: rtl/cem_collision.sv
module cem_collision #(
    parameter int N     = 4,
    parameter int TAG_W = 26
) (
    input  logic               snoop_valid,
    input  logic [TAG_W-1:0]   snoop_line,
    input  logic [N-1:0]       valid,
    input  logic [N-1:0]       dirty,
    input  logic [N*TAG_W-1:0] tags,
    output logic [N-1:0]       hit
);
    for (genvar n = 0; n < N; n++) begin : g_line
        logic tag_eq_d;
        always_comb begin
            tag_eq_d = (tags[n*TAG_W +: TAG_W] == snoop_line);
            hit[n]   = snoop_valid && valid[n] && dirty[n] && tag_eq_d;
        end
    end
endmodule

// File: rtl/cem_status_reg.sv
module cem_status_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_set,
    input  logic         sw_wr,
    input  logic         sw_sel,
    input  logic [W-1:0] sw_wdata,
    output logic [W-1:0] status_q
);
    import cem_pkg::*;

    typedef struct packed {
        logic [W-1:0] bits;
    } stat_t;

    stat_t st_d, st_q;
    logic [W-1:0] clr_d, set_d;

    always_comb begin
        clr_d = (sw_wr && sw_sel == SW_SEL_CLR) ? sw_wdata : '0;
        set_d = (sw_wr && sw_sel == SW_SEL_SET) ? sw_wdata : '0;
        // clear first, then OR in sets so a hardware event wins
        st_d.bits = (st_q.bits & ~clr_d) | set_d | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_q = st_q.bits;
endmodule

// File: rtl/cem_patch_gen.sv
module cem_patch_gen #(
    parameter int               PATCH_W = 32,
    parameter int               SIG_W   = 12,
    parameter logic [SIG_W-1:0] SIG_VAL = 12'hBAD,
    localparam int              OFS_W   = PATCH_W - SIG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nack,
    input  logic [OFS_W-1:0]   offset,
    output logic               patch_valid_q,
    output logic [PATCH_W-1:0] patch_data_q
);
    typedef struct packed {
        logic               vld;
        logic [PATCH_W-1:0] data;
    } patch_t;

    patch_t pt_d, pt_q;

    always_comb begin
        pt_d.vld  = nack;
        pt_d.data = nack ? {offset, SIG_VAL} : pt_q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '0;
        else        pt_q <= pt_d;
    end

    assign patch_valid_q = pt_q.vld;
    assign patch_data_q  = pt_q.data;
endmodule

// File: rtl/cache_err_monitor.sv
module cache_err_monitor #(
    parameter int               NUM_LINES = 4,
    parameter int               TAG_W     = 26,
    parameter int               PATCH_W   = 32,
    parameter int               SIG_W     = 12,
    parameter logic [SIG_W-1:0] SIG_VAL   = 12'hBAD,
    parameter logic [7:0]       HDR_OFS   = 8'h0C,
    localparam int              IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int              OFS_W     = PATCH_W - SIG_W,
    localparam int              STAT_W    = NUM_LINES + cem_pkg::NUM_EVT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en,
    input  logic [NUM_LINES-1:0]      rd_hit,
    input  logic                      wr_en,
    input  logic [NUM_LINES-1:0]      wr_hit,
    input  logic [NUM_LINES-1:0]      line_valid,
    input  logic [NUM_LINES-1:0]      line_dirty,
    input  logic [NUM_LINES*TAG_W-1:0] line_tag,
    input  logic                      snoop_valid,
    input  logic [TAG_W-1:0]          snoop_line,
    input  logic                      inval_req,
    input  logic [IDX_W-1:0]          inval_line,
    input  logic                      nack_pulse,
    input  logic [OFS_W-1:0]          nack_offset,
    input  logic                      sw_wr,
    input  logic                      sw_sel,
    input  logic [STAT_W-1:0]         sw_wdata,
    output logic [STAT_W-1:0]         status,
    output logic                      patch_valid,
    output logic [7:0]                patch_hdr_ofs,
    output logic [PATCH_W-1:0]        patch_data
);
    import cem_pkg::*;

    logic                 rd_multi_d, wr_multi_d, inv_dirty_d;
    logic [NUM_LINES-1:0] coll_d;
    logic [STAT_W-1:0]    hw_set_d;

    cem_multihit #(.N(NUM_LINES)) u_rd_multi (
        .en(rd_en), .hit(rd_hit), .valid(line_valid), .multi(rd_multi_d)
    );

    cem_multihit #(.N(NUM_LINES)) u_wr_multi (
        .en(wr_en), .hit(wr_hit), .valid(line_valid), .multi(wr_multi_d)
    );

    cem_collision #(.N(NUM_LINES), .TAG_W(TAG_W)) u_coll (
        .snoop_valid(snoop_valid), .snoop_line(snoop_line),
        .valid(line_valid), .dirty(line_dirty), .tags(line_tag), .hit(coll_d)
    );

    always_comb begin
        inv_dirty_d = inval_req && line_valid[inval_line] && line_dirty[inval_line];
        hw_set_d                             = '0;
        hw_set_d[NUM_LINES-1:0]              = coll_d;
        hw_set_d[NUM_LINES + EVT_NACK]       = nack_pulse;
        hw_set_d[NUM_LINES + EVT_RD_MULTI]   = rd_multi_d;
        hw_set_d[NUM_LINES + EVT_WR_MULTI]   = wr_multi_d;
        hw_set_d[NUM_LINES + EVT_INV_DIRTY]  = inv_dirty_d;
    end

    cem_status_reg #(.W(STAT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set_d),
        .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_wdata(sw_wdata), .status_q(status)
    );

    cem_patch_gen #(.PATCH_W(PATCH_W), .SIG_W(SIG_W), .SIG_VAL(SIG_VAL)) u_patch (
        .clk(clk), .rst_n(rst_n), .nack(nack_pulse), .offset(nack_offset),
        .patch_valid_q(patch_valid), .patch_data_q(patch_data)
    );

    assign patch_hdr_ofs = HDR_OFS;
endmodule

// File: rtl/cem_checker.sv
module cem_checker #(
    parameter int               N       = 4,
    parameter int               W       = 8,
    parameter int               PATCH_W = 32,
    parameter int               SIG_W   = 12,
    parameter logic [SIG_W-1:0] SIG_VAL = 12'hBAD
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_en,
    input logic [N-1:0]       rd_hit,
    input logic               wr_en,
    input logic [N-1:0]       wr_hit,
    input logic [N-1:0]       line_valid,
    input logic               nack_pulse,
    input logic               sw_wr,
    input logic               sw_sel,
    input logic [W-1:0]       status,
    input logic               patch_valid,
    input logic [PATCH_W-1:0] patch_data
);
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && !patch_valid));

    a_r5_rd_multi: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $countones(rd_hit & line_valid) >= 2) |=> status[N+1]);

    a_r4_wr_multi: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $countones(wr_hit & line_valid) >= 2) |=> status[N+2]);

    a_r6_nack_flag: assert property (@(posedge clk) disable iff (!rst_n)
        nack_pulse |=> status[N]);

    a_r7_patch_word: assert property (@(posedge clk) disable iff (!rst_n)
        nack_pulse |=> (patch_valid && patch_data[SIG_W-1:0] == SIG_VAL));

    a_r7_patch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !nack_pulse |=> !patch_valid);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(sw_wr && sw_sel) |=> ((status & $past(status)) == $past(status)));

    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_pulse && sw_wr && sw_sel) |=> status[N]);
endmodule

bind cache_err_monitor cem_checker #(
    .N(NUM_LINES), .W(STAT_W), .PATCH_W(PATCH_W), .SIG_W(SIG_W), .SIG_VAL(SIG_VAL)
) u_cem_checker (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_hit(rd_hit), .wr_en(wr_en),
    .wr_hit(wr_hit), .line_valid(line_valid), .nack_pulse(nack_pulse),
    .sw_wr(sw_wr), .sw_sel(sw_sel), .status(status),
    .patch_valid(patch_valid), .patch_data(patch_data)
);

// File: tb/tb_cache_err_monitor.sv
`timescale 1ns/1ps
module tb_cache_err_monitor;
    localparam int N = 4;
    localparam int TAG_W = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en, wr_en, snoop_valid, inval_req, nack_pulse, sw_wr, sw_sel;
    logic [N-1:0] rd_hit, wr_hit, line_valid, line_dirty;
    logic [N*TAG_W-1:0] line_tag;
    logic [TAG_W-1:0] snoop_line;
    logic [1:0] inval_line;
    logic [19:0] nack_offset;
    logic [7:0] sw_wdata, status, patch_hdr_ofs;
    logic patch_valid;
    logic [31:0] patch_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;  // 125 MHz

    cache_err_monitor dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_hit(rd_hit), .wr_en(wr_en),
        .wr_hit(wr_hit), .line_valid(line_valid), .line_dirty(line_dirty),
        .line_tag(line_tag), .snoop_valid(snoop_valid), .snoop_line(snoop_line),
        .inval_req(inval_req), .inval_line(inval_line), .nack_pulse(nack_pulse),
        .nack_offset(nack_offset), .sw_wr(sw_wr), .sw_sel(sw_sel),
        .sw_wdata(sw_wdata), .status(status), .patch_valid(patch_valid),
        .patch_hdr_ofs(patch_hdr_ofs), .patch_data(patch_data)
    );

    function automatic logic [TAG_W-1:0] tag_of(input int n);
        return TAG_W'(32'h100 + n * 3);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        rd_en = 0; wr_en = 0; rd_hit = '0; wr_hit = '0;
        line_valid = '0; line_dirty = '0;
        snoop_valid = 0; snoop_line = '0; inval_req = 0; inval_line = '0;
        nack_pulse = 0; nack_offset = '0; sw_wr = 0; sw_sel = 0; sw_wdata = '0;
    endtask

    // apply current inputs over one rising edge, then idle; called at negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic sw_clear_all();
        sw_wr = 1; sw_sel = 1; sw_wdata = 8'hFF;
        step();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int n = 0; n < N; n++) line_tag[n*TAG_W +: TAG_W] = tag_of(n);
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(status == 8'h00, "R1 status", 32'(status), 32'h0);
        chk(patch_valid == 0, "R1 patch_valid", 32'(patch_valid), 32'h0);
        rst_n = 1;
        @(negedge clk);

        // R2: set and clear ports
        sw_wr = 1; sw_sel = 0; sw_wdata = 8'hA5; step();
        chk(status == 8'hA5, "R2 set port", 32'(status), 32'hA5);
        sw_wr = 1; sw_sel = 1; sw_wdata = 8'h21; step();
        chk(status == 8'h84, "R2 clear port", 32'(status), 32'h84);
        sw_clear_all();
        chk(status == 8'h00, "R2 clear all", 32'(status), 32'h0);

        // R5/R4: exhaustive multi-hit sweeps
        for (int h = 0; h < 16; h++) begin
            for (int v = 0; v < 16; v++) begin
                logic [7:0] exp;
                exp = ($countones(4'(h) & 4'(v)) >= 2) ? 8'h20 : 8'h00;
                rd_en = 1; rd_hit = 4'(h); line_valid = 4'(v); step();
                chk(status == exp, "R5 read multi-hit", 32'(status), 32'(exp));
                sw_clear_all();
                exp = ($countones(4'(h) & 4'(v)) >= 2) ? 8'h40 : 8'h00;
                wr_en = 1; wr_hit = 4'(h); line_valid = 4'(v); step();
                chk(status == exp, "R4 write multi-hit", 32'(status), 32'(exp));
                sw_clear_all();
            end
        end

        // R10: hit vectors ignored without strobes
        rd_hit = 4'hF; wr_hit = 4'hF; line_valid = 4'hF; step();
        chk(status == 8'h00, "R10 strobes low", 32'(status), 32'h0);

        // R8 collision and R3 invalidate sweeps
        for (int v = 0; v < 16; v++) begin
            for (int d = 0; d < 16; d++) begin
                for (int s = 0; s < N; s++) begin
                    logic [7:0] exp;
                    exp = (v[s] && d[s]) ? 8'(1 << s) : 8'h00;
                    snoop_valid = 1; snoop_line = tag_of(s);
                    line_valid = 4'(v); line_dirty = 4'(d); step();
                    chk(status == exp, "R8 collision", 32'(status), 32'(exp));
                    sw_clear_all();
                    exp = (v[s] && d[s]) ? 8'h80 : 8'h00;
                    inval_req = 1; inval_line = 2'(s);
                    line_valid = 4'(v); line_dirty = 4'(d); step();
                    chk(status == exp, "R3 invalidate dirty", 32'(status), 32'(exp));
                    sw_clear_all();
                end
            end
        end
        snoop_valid = 1; snoop_line = TAG_W'(32'h7FF);
        line_valid = 4'hF; line_dirty = 4'hF; step();
        chk(status == 8'h00, "R8 no tag match", 32'(status), 32'h0);

        // R6/R7: negative acknowledge and patch word
        for (int k = 0; k < 5; k++) begin
            logic [19:0] ofs;
            ofs = 20'(k * 32'h3A7C9 + 1);
            nack_pulse = 1; nack_offset = ofs;
            @(posedge clk); @(negedge clk); idle_inputs();
            chk(status == 8'h10, "R6 nack flag", 32'(status), 32'h10);
            chk(patch_valid == 1, "R7 patch valid", 32'(patch_valid), 32'h1);
            chk(patch_data == {ofs, 12'hBAD}, "R7 patch data", patch_data, {ofs, 12'hBAD});
            chk(patch_hdr_ofs == 8'h0C, "R7 patch offset", 32'(patch_hdr_ofs), 32'hC);
            @(posedge clk); @(negedge clk);
            chk(patch_valid == 0, "R7 single pulse", 32'(patch_valid), 32'h0);
            sw_clear_all();
        end

        // R9: sticky and set wins over clear
        rd_en = 1; rd_hit = 4'h3; line_valid = 4'h3; step();
        repeat (5) @(negedge clk);
        chk(status == 8'h20, "R9 sticky", 32'(status), 32'h20);
        sw_wr = 1; sw_sel = 1; sw_wdata = 8'h10; step();
        chk(status == 8'h20, "R9 clear other bit only", 32'(status), 32'h20);
        nack_pulse = 1; sw_wr = 1; sw_sel = 1; sw_wdata = 8'hFF; step();
        chk(status == 8'h10, "R9 set wins", 32'(status), 32'h10);

        finish_run();
    end
endmodule